// File: doc/BRIEF.md
# Double-Rate Interpolating Filter Stage

This block runs one second-order IIR section at twice the rate of its input stream. Each accepted input sample starts two filter passes on two consecutive clocks, so the output stream carries two samples for every input sample. The extra samples fill in values between the input samples, which relaxes the reconstruction filtering needed after the output.

The first pass always takes the real sample. A mode bit sets the input of the second pass. In hold mode the second pass takes the same sample again, which behaves like a sampled-and-held source. In zero mode the second pass takes zero, which behaves like zero stuffing with impulses. The two modes give different frequency responses. The mode is captured together with each sample. The filter coefficients are fixed by parameters. A sample that arrives while the second pass is still pending is dropped, and a sticky overrun flag records the loss.

Top module: `dbl_rate_interp`

## Requirements
- R1: An input sample is accepted on a clock edge where `in_valid_i` is high and no second pass is pending. `out_valid_o` is then high for exactly the two following cycles (pass one, then pass two), unless a new sample is accepted.
- R2: Pass one filters the accepted sample itself, and its result is on `out_data_o` in the first cycle after acceptance.
- R3: With `zero_mode_i` = 0 at acceptance (hold mode), pass two filters the same sample again.
- R4: With `zero_mode_i` = 1 at acceptance (zero mode), pass two filters the value zero.
- R5: The mode is sampled only at acceptance. A change of `zero_mode_i` during the pending cycle has no effect on pass two.
- R6: Each pass computes acc = B0*x + B1*x1 + B2*x2 - A1*y1 - A2*y2 over the previous two pass inputs and outputs. The result is acc arithmetically shifted right by CF bits (rounding toward minus infinity). Defaults: B0=4096, B1=8192, B2=4096, A1=-8192, A2=2048, CF=14.
- R7: The shifted result saturates to the signed DW-bit range [-32768, 32767] by default. The saturated value is both the output and the stored y1.
- R8: When `in_valid_i` is high while pass two is pending, the sample is ignored. It changes neither the outputs nor the filter state.
- R9: An ignored sample sets `overrun_o` one cycle later. The flag stays set until reset.
- R10: Reset clears `out_valid_o`, `out_data_o`, `overrun_o` and all filter state to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, running at twice the input sample rate or faster |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | DW | Signed input sample |
| zero_mode_i | input | 1 | Second-pass input select: 0 = hold, 1 = zero |
| out_valid_o | output | 1 | One-clock strobe for each output sample |
| out_data_o | output | DW | Signed, saturated filter output |
| overrun_o | output | 1 | Sticky flag for a dropped input sample |

## Verification
A wrong delay-line value or a wrong second-pass input shows up on `out_data_o` at once, in the pass that uses it. Because the section is recursive, the error then spreads into every later output. A pending flag stuck high or low shows up within one cycle, either as a missing or extra `out_valid_o` pulse or as a false overrun. A wrongly latched mode corrupts only pass two of that sample, one cycle after pass one.

// File: rtl/dri_pkg.sv
package dri_pkg;
  localparam int DRI_DW = 16;
  localparam int DRI_CW = 16;
  localparam int DRI_CF = 14;
endpackage

// File: rtl/dri_seq.sv
module dri_seq #(
  parameter int DW = dri_pkg::DRI_DW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic signed [DW-1:0] in_data_i,
  input  logic                 zero_mode_i,
  output logic                 step_o,
  output logic signed [DW-1:0] x_o,
  output logic                 pend_o,
  output logic                 accept_o,
  output logic                 overrun_o
);
  logic                 pend_q, mode_q, ovr_q;
  logic signed [DW-1:0] x_q;

  assign accept_o  = in_valid_i & ~pend_q;
  assign step_o    = accept_o | pend_q;
  assign pend_o    = pend_q;
  assign overrun_o = ovr_q;
  // pass one takes the live sample, pass two the held or zero value
  assign x_o = pend_q ? (mode_q ? '0 : x_q) : in_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      mode_q <= 1'b0;
      x_q    <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (accept_o) begin
        pend_q <= 1'b1;
        mode_q <= zero_mode_i;
        x_q    <= in_data_i;
      end else if (pend_q) begin
        pend_q <= 1'b0;
      end
      if (in_valid_i && pend_q) ovr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dri_sos.sv
module dri_sos #(
  parameter int DW = dri_pkg::DRI_DW,
  parameter int CW = dri_pkg::DRI_CW,
  parameter int CF = dri_pkg::DRI_CF,
  parameter int B0 = 4096,
  parameter int B1 = 8192,
  parameter int B2 = 4096,
  parameter int A1 = -8192,
  parameter int A2 = 2048
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] y_o
);
  localparam int PW = DW + CW;
  localparam int AW = PW + 3;
  localparam int NT = 5;
  localparam logic [CW-1:0] B0C = CW'(B0);
  localparam logic [CW-1:0] B1C = CW'(B1);
  localparam logic [CW-1:0] B2C = CW'(B2);
  localparam logic [CW-1:0] A1C = CW'(A1);
  localparam logic [CW-1:0] A2C = CW'(A2);
  localparam logic signed [DW-1:0] YMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] YMIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] x1_q, x2_q, y1_q, y2_q;
  logic [DW-1:0] opd [NT];
  logic [CW-1:0] cof [NT];
  logic signed [AW-1:0] term [NT];
  logic signed [AW-1:0] acc, sh;
  logic signed [DW-1:0] y_sat;

  assign opd[0] = x_i;  assign cof[0] = B0C;
  assign opd[1] = x1_q; assign cof[1] = B1C;
  assign opd[2] = x2_q; assign cof[2] = B2C;
  assign opd[3] = y1_q; assign cof[3] = A1C;
  assign opd[4] = y2_q; assign cof[4] = A2C;

  for (genvar i = 0; i < NT; i++) begin : g_mul
    logic [PW-1:0] prod;
    assign prod    = {{CW{opd[i][DW-1]}}, opd[i]} * {{DW{cof[i][CW-1]}}, cof[i]};
    assign term[i] = {{(AW-PW){prod[PW-1]}}, prod};
  end

  assign acc = term[0] + term[1] + term[2] - term[3] - term[4];
  assign sh  = acc >>> CF;

  always_comb begin
    if (sh[AW-1:DW-1] != {(AW-DW+1){sh[AW-1]}}) y_sat = sh[AW-1] ? YMIN : YMAX;
    else                                         y_sat = sh[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0; x2_q <= '0; y1_q <= '0; y2_q <= '0;
    end else if (step_i) begin
      x2_q <= x1_q;
      x1_q <= x_i;
      y2_q <= y1_q;
      y1_q <= y_sat;
    end
  end

  assign y_o = y1_q;
endmodule

// File: rtl/dbl_rate_interp.sv
module dbl_rate_interp #(
  parameter int DW = dri_pkg::DRI_DW,
  parameter int CW = dri_pkg::DRI_CW,
  parameter int CF = dri_pkg::DRI_CF,
  parameter int B0 = 4096,
  parameter int B1 = 8192,
  parameter int B2 = 4096,
  parameter int A1 = -8192,
  parameter int A2 = 2048
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic signed [DW-1:0] in_data_i,
  input  logic                 zero_mode_i,
  output logic                 out_valid_o,
  output logic signed [DW-1:0] out_data_o,
  output logic                 overrun_o
);
  logic                 step, pend, accept;
  logic signed [DW-1:0] x_pass;
  logic                 ovalid_q;

  dri_seq #(.DW(DW)) u_seq (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .zero_mode_i,
    .step_o(step), .x_o(x_pass), .pend_o(pend), .accept_o(accept),
    .overrun_o(overrun_o)
  );

  dri_sos #(
    .DW(DW), .CW(CW), .CF(CF),
    .B0(B0), .B1(B1), .B2(B2), .A1(A1), .A2(A2)
  ) u_sos (
    .clk_i, .rst_ni, .step_i(step), .x_i(x_pass), .y_o(out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovalid_q <= 1'b0;
    else         ovalid_q <= step;
  end
  assign out_valid_o = ovalid_q;
endmodule

// File: rtl/dbl_rate_interp_chk.sv
module dbl_rate_interp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic out_valid_o,
  input logic overrun_o,
  input logic pend,
  input logic accept
);
  AST_ACCEPT_PASS1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o && pend); // R1
  AST_PEND_PASS2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |=> out_valid_o && !pend); // R1
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && pend |=> !pend); // R8
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && pend |=> overrun_o); // R9
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept && !pend |=> !out_valid_o); // R1
endmodule

bind dbl_rate_interp dbl_rate_interp_chk u_chk (
  .clk_i, .rst_ni, .in_valid_i, .out_valid_o, .overrun_o,
  .pend(pend), .accept(accept)
);

// File: tb/dbl_rate_interp_tb_top.sv
module dbl_rate_interp_tb_top;
  localparam int DW = 16;
  localparam int CF = 14;
  localparam longint B0 = 4096, B1 = 8192, B2 = 4096, A1 = -8192, A2 = 2048;
  localparam longint YMAX = 32767, YMIN = -32768;
  localparam int NV = 10;
  localparam logic signed [DW-1:0] VEC_X [NV] =
    '{16'sd1000, 16'sd1000, -16'sd500, 16'sd12000, 16'sd0,
      -16'sd20000, 16'sd7, 16'sd30000, -16'sd30000, 16'sd123};
  localparam bit VEC_M [NV] = '{0, 1, 0, 1, 1, 0, 1, 0, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic zero_mode = 1'b0;
  logic out_valid;
  logic signed [DW-1:0] out_data;
  logic overrun;
  int n_run = 0, n_fail = 0;
  longint mx1, mx2, my1, my2;

  always #2 clk = ~clk;

  dbl_rate_interp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .zero_mode_i(zero_mode), .out_valid_o(out_valid), .out_data_o(out_data),
    .overrun_o(overrun)
  );

  function automatic void m_reset();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
  endfunction

  function automatic longint m_step(longint x);
    longint acc, y;
    acc = B0*x + B1*mx1 + B2*mx2 - A1*my1 - A2*my2;
    y = acc >>> CF;
    if (y > YMAX) y = YMAX;
    if (y < YMIN) y = YMIN;
    mx2 = mx1; mx1 = x; my2 = my1; my1 = y;
    return y;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_sample(input logic signed [DW-1:0] x, input bit m, input string req);
    @(negedge clk); in_valid = 1'b1; in_data = x; zero_mode = m;
    @(negedge clk); in_valid = 1'b0;
    chk({req, " R1 pass1 valid"}, out_valid, 1);
    chk({req, " R2 pass1 data"}, out_data, m_step(x));
    @(negedge clk);
    chk({req, " R1 pass2 valid"}, out_valid, 1);
    chk({req, m ? " R4 pass2 zero" : " R3 pass2 hold"}, out_data, m_step(m ? 0 : longint'(x)));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    chk("R10 reset valid", out_valid, 0);
    chk("R10 reset data", out_data, 0);
    chk("R10 reset overrun", overrun, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle no valid", out_valid, 0);

    for (int i = 0; i < NV; i++) run_sample(VEC_X[i], VEC_M[i], "R6 vec");
    @(negedge clk);
    chk("R1 no third pulse", out_valid, 0);

    // R5: mode flips after acceptance
    @(negedge clk); in_valid = 1'b1; in_data = 16'sd4000; zero_mode = 1'b1;
    @(negedge clk); in_valid = 1'b0; zero_mode = 1'b0;
    chk("R5 pass1", out_data, m_step(4000));
    @(negedge clk);
    chk("R5 latched zero mode", out_data, m_step(0));
    @(negedge clk); in_valid = 1'b1; in_data = 16'sd4000; zero_mode = 1'b0;
    @(negedge clk); in_valid = 1'b0; zero_mode = 1'b1;
    chk("R5 pass1 b", out_data, m_step(4000));
    @(negedge clk);
    chk("R5 latched hold mode", out_data, m_step(4000));

    // R8/R9: sample during pending pass two
    @(negedge clk); in_valid = 1'b1; in_data = 16'sd1000; zero_mode = 1'b0;
    @(negedge clk); in_data = -16'sd20000; zero_mode = 1'b1;
    chk("R2 pass1 before drop", out_data, m_step(1000));
    chk("R9 overrun not yet", overrun, 0);
    @(negedge clk); in_valid = 1'b0;
    chk("R8 pass2 unaffected", out_data, m_step(1000));
    chk("R9 overrun set", overrun, 1);
    @(negedge clk);
    chk("R8 no extra output", out_valid, 0);
    run_sample(16'sd2500, 1'b0, "R8 state intact");
    chk("R9 overrun sticky", overrun, 1);

    // R7: saturation both ways
    for (int i = 0; i < 6; i++) run_sample(16'sd32767, 1'b0, "R7 pos");
    chk("R7 positive clip", out_data, YMAX);
    for (int i = 0; i < 8; i++) run_sample(-16'sd32768, 1'b0, "R7 neg");
    chk("R7 negative clip", out_data, YMIN);

    // R10: reset again clears flag and state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R10 overrun cleared", overrun, 0);
    chk("R10 data cleared", out_data, 0);
    rst_n = 1'b1; m_reset();
    run_sample(16'sd5000, 1'b1, "R10 fresh state");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule